// File: doc/BRIEF.md
# Synchronous Processor Bus Register Slave

This block connects a small bank of control and status registers to a clocked microprocessor bus. The address phase and the data phase share one strobe. While chip select is low, a clock edge that sees the address strobe low captures the address. The next edge that sees the strobe high starts exactly one access at that address. The write/read control, sampled on that same edge, picks the direction. A read drives the data outputs for the following clock period, gated by an output-enable pin that acts without the clock. A write takes the data present at the end of that period, provided chip select is still low then. Every access therefore takes two clocks.

A strap input picks the bus width. In 16-bit mode each access moves a whole register word. In 8-bit mode only the low byte lane is used, and the low address bit picks which half of the word is reached. The bank holds scratch words, a read-only identity word, a status word with a sticky protocol-error flag, and two interrupt groups. Each group has a pending word and a mask word. Each group drives one active-low open-drain interrupt, modelled as a pull-down enable: the output is 1 when the pin is pulled low and 0 when the pin floats.

Control pins are plain level signals. The bus has no handshake, so the data lanes use no valid/ready pair. A read returns data in the fixed period after the command, and the host cannot stall the slave.

Top module: `pbus_reg_slave`

## Requirements
- R1: With `cs_n` low, an edge with `as_n` low captures `addr_i`. While `as_n` stays low, each edge reloads the address and no access takes place: `data_oe` stays 0 and nothing is written.
- R2: With `cs_n` low, the first edge with `as_n` high after an address edge and `wr_hi` low starts a read. During the next clock period `data_o` carries the register at the latched address. The data lanes are enabled only while `oe_n` is low; when `oe_n` is high, `data_oe` is 0.
- R3: The same edge with `wr_hi` high starts a write. The data on `data_i` at the next edge is stored only if `cs_n` is still low at that edge; otherwise it is dropped.
- R4: In 16-bit mode (`narrow` = 0) the word index is `addr_i[3:1]` and `addr_i[0]` is ignored. Reads enable all 16 lanes.
- R5: In 8-bit mode (`narrow` = 1), `addr_i[0]` picks the byte: 0 is bits 7:0 of the word and 1 is bits 15:8. Only `data_i[7:0]` is written. Reads return the byte on `data_o[7:0]`; `data_o[15:8]` reads 0 and `data_oe[15:8]` stays 0.
- R6: Word indices 0 and 1 are read/write scratch words. Word 7 is read-only and always reads 16'h5A3C; writes to it have no effect. Word 6 is status: bit 0 is the sticky protocol-error flag and is cleared by writing 1, and bit 1 shows the width strap.
- R7: A pulse on `dl_evt[i]` sets bit i of the data-link pending word (index 2), and a pulse on `st_evt[i]` sets bit i of the status pending word (index 4). Writing 1 to a pending bit clears it; if an event arrives in the same cycle, the event wins. The masks are index 3 and index 5, and 1 enables a bit. `dl_irq_pd` or `st_irq_pd` is 1 exactly when its group has a pending bit that is also enabled.
- R8: An edge that sees `cs_n` low and `as_n` high without a preceding address edge is illegal. It sets the protocol-error flag and starts no access.
- R9: `cs_n` high at an edge abandons any latched address and any access in progress. Reset clears the address, all registers, all pending bits and both interrupt pull-downs.
- R10: The mask and pending words are 4 bits wide for the data-link group and 6 bits wide for the status group. The unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow | input | 1 | Width strap: 1 selects 8-bit, 0 selects 16-bit |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| wr_hi | input | 1 | Direction: 1 write, 0 read |
| oe_n | input | 1 | Output enable, active low, not clocked |
| addr_i | input | 4 | Address; bits 3:1 word index, bit 0 byte select |
| data_i | input | 16 | Incoming write data lanes |
| data_o | output | 16 | Outgoing read data lanes |
| data_oe | output | 16 | Per-lane drive enable; 0 means high-impedance |
| dl_evt | input | 4 | Data-link event pulses |
| st_evt | input | 6 | Status/counter event pulses |
| dl_irq_pd | output | 1 | Data-link interrupt pull-down enable |
| st_irq_pd | output | 1 | Status interrupt pull-down enable |

## Verification
The bench builds the block with its default parameters: two scratch words, a 4-bit data-link group, a 6-bit status group and identity value 16'h5A3C. Because the group widths differ and are both narrower than a byte, one write of all ones shows that each group keeps only its own bits. The 8-bit strap is switched between accesses, so the same scratch word can be filled byte by byte and then read back whole. With the identity word fixed, the bench can check both a multi-edge address strobe and an illegal second strobe-high edge against one known value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int BUS_W  = 16;
  localparam int LANE_W = BUS_W / 2;
  localparam int WIDX_W = 3;

  localparam logic [WIDX_W-1:0] IDX_DL_PEND = 3'd2;
  localparam logic [WIDX_W-1:0] IDX_DL_MASK = 3'd3;
  localparam logic [WIDX_W-1:0] IDX_ST_PEND = 3'd4;
  localparam logic [WIDX_W-1:0] IDX_ST_MASK = 3'd5;
  localparam logic [WIDX_W-1:0] IDX_STAT    = 3'd6;
  localparam logic [WIDX_W-1:0] IDX_IDENT   = 3'd7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_t;
endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int ADDR_W = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              as_n,
  input  logic              wr_hi,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_act,
  output logic              wr_go,
  output logic              err_set
);
  phase_t phase;
  logic   armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      armed  <= 1'b0;
      addr_q <= '0;
    end else if (cs_n) begin
      phase <= PH_IDLE;
      armed <= 1'b0;
    end else if (!as_n) begin
      addr_q <= addr_i;
      armed  <= 1'b1;
      phase  <= PH_IDLE;
    end else if (armed) begin
      phase <= wr_hi ? PH_WR : PH_RD;
      armed <= 1'b0;
    end else begin
      phase <= PH_IDLE;
    end
  end

  assign rd_act  = (phase == PH_RD);
  assign wr_go   = (phase == PH_WR) && !cs_n;
  assign err_set = !cs_n && as_n && !armed;
endmodule

// File: rtl/pbus_irq_grp.sv
module pbus_irq_grp
  import pbus_pkg::*;
#(
  parameter int N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     evt,
  input  logic             mask_we,
  input  logic             pend_we,
  input  logic [BUS_W-1:0] wd,
  input  logic [BUS_W-1:0] lane_mask,
  output logic [N-1:0]     pend,
  output logic [N-1:0]     mask,
  output logic             irq_pd
);
  logic [N-1:0] wbits;
  logic [N-1:0] wsel;
  logic [N-1:0] clr;

  assign wbits = wd[N-1:0];
  assign wsel  = lane_mask[N-1:0];
  assign clr   = pend_we ? (wbits & wsel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= (pend & ~clr) | evt;
      if (mask_we) mask <= (mask & ~wsel) | (wbits & wsel);
    end
  end

  assign irq_pd = |(pend & mask);
endmodule

// File: rtl/pbus_regs.sv
module pbus_regs
  import pbus_pkg::*;
#(
  parameter int          N_SCR   = 2,
  parameter int          DL_N    = 4,
  parameter int          ST_N    = 6,
  parameter logic [15:0] ID_VAL  = 16'h5A3C,
  localparam int         ADDR_W  = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              wr_go,
  input  logic              err_set,
  input  logic [BUS_W-1:0]  data_i,
  input  logic [DL_N-1:0]   dl_evt,
  input  logic [ST_N-1:0]   st_evt,
  output logic [BUS_W-1:0]  rd_word,
  output logic              dl_irq_pd,
  output logic              st_irq_pd
);
  logic [WIDX_W-1:0] widx;
  logic              bsel;
  logic [BUS_W-1:0]  wd;
  logic [1:0]        be;
  logic [BUS_W-1:0]  lm;
  logic [BUS_W-1:0]  scr_rd [N_SCR];
  logic [DL_N-1:0]   dl_pend, dl_mask;
  logic [ST_N-1:0]   st_pend, st_mask;
  logic              err_q;
  logic              err_clr;

  assign widx = addr_q[ADDR_W-1:1];
  assign bsel = addr_q[0];
  assign wd   = narrow ? {data_i[LANE_W-1:0], data_i[LANE_W-1:0]} : data_i;
  assign be   = narrow ? (bsel ? 2'b10 : 2'b01) : 2'b11;
  assign lm   = {{LANE_W{be[1]}}, {LANE_W{be[0]}}};

  for (genvar g = 0; g < N_SCR; g++) begin : g_scr
    logic [BUS_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_go && widx == WIDX_W'(g)) q <= (q & ~lm) | (wd & lm);
    end
    assign scr_rd[g] = q;
  end

  pbus_irq_grp #(.N(DL_N)) u_dl (
    .clk(clk), .rst_n(rst_n), .evt(dl_evt),
    .mask_we(wr_go && widx == IDX_DL_MASK),
    .pend_we(wr_go && widx == IDX_DL_PEND),
    .wd(wd), .lane_mask(lm),
    .pend(dl_pend), .mask(dl_mask), .irq_pd(dl_irq_pd)
  );

  pbus_irq_grp #(.N(ST_N)) u_st (
    .clk(clk), .rst_n(rst_n), .evt(st_evt),
    .mask_we(wr_go && widx == IDX_ST_MASK),
    .pend_we(wr_go && widx == IDX_ST_PEND),
    .wd(wd), .lane_mask(lm),
    .pend(st_pend), .mask(st_mask), .irq_pd(st_irq_pd)
  );

  assign err_clr = wr_go && widx == IDX_STAT && wd[0] && lm[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (err_q & ~err_clr) | err_set;
  end

  always_comb begin
    rd_word = '0;
    case (widx)
      IDX_DL_PEND: rd_word = {{(BUS_W-DL_N){1'b0}}, dl_pend};
      IDX_DL_MASK: rd_word = {{(BUS_W-DL_N){1'b0}}, dl_mask};
      IDX_ST_PEND: rd_word = {{(BUS_W-ST_N){1'b0}}, st_pend};
      IDX_ST_MASK: rd_word = {{(BUS_W-ST_N){1'b0}}, st_mask};
      IDX_STAT:    rd_word = {{(BUS_W-2){1'b0}}, narrow, err_q};
      IDX_IDENT:   rd_word = ID_VAL;
      default: begin
        for (int k = 0; k < N_SCR; k++)
          if (widx == WIDX_W'(k)) rd_word = scr_rd[k];
      end
    endcase
  end
endmodule

// File: rtl/pbus_reg_slave.sv
module pbus_reg_slave
  import pbus_pkg::*;
#(
  parameter int          N_SCR  = 2,
  parameter int          DL_N   = 4,
  parameter int          ST_N   = 6,
  parameter logic [15:0] ID_VAL = 16'h5A3C,
  localparam int         ADDR_W = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              cs_n,
  input  logic              as_n,
  input  logic              wr_hi,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic [BUS_W-1:0]  data_o,
  output logic [BUS_W-1:0]  data_oe,
  input  logic [DL_N-1:0]   dl_evt,
  input  logic [ST_N-1:0]   st_evt,
  output logic              dl_irq_pd,
  output logic              st_irq_pd
);
  logic [ADDR_W-1:0] addr_q;
  logic              rd_act, wr_go, err_set, drv;
  logic [BUS_W-1:0]  rd_word;

  pbus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .wr_hi(wr_hi),
    .addr_i(addr_i), .addr_q(addr_q), .rd_act(rd_act), .wr_go(wr_go),
    .err_set(err_set)
  );

  pbus_regs #(.N_SCR(N_SCR), .DL_N(DL_N), .ST_N(ST_N), .ID_VAL(ID_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .addr_q(addr_q),
    .wr_go(wr_go), .err_set(err_set), .data_i(data_i),
    .dl_evt(dl_evt), .st_evt(st_evt), .rd_word(rd_word),
    .dl_irq_pd(dl_irq_pd), .st_irq_pd(st_irq_pd)
  );

  assign drv = rd_act && !oe_n;

  always_comb begin
    if (!drv) begin
      data_o  = '0;
      data_oe = '0;
    end else if (narrow) begin
      data_o  = {{LANE_W{1'b0}}, addr_q[0] ? rd_word[BUS_W-1:LANE_W] : rd_word[LANE_W-1:0]};
      data_oe = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
    end else begin
      data_o  = rd_word;
      data_oe = '1;
    end
  end
endmodule

// File: rtl/pbus_reg_slave_chk.sv
module pbus_reg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        narrow,
  input logic        cs_n,
  input logic        as_n,
  input logic        wr_hi,
  input logic        oe_n,
  input logic [15:0] data_oe,
  input logic        dl_irq_pd,
  input logic        st_irq_pd
);
  AST_OE_GATES_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> data_oe == 16'h0000); // R2

  AST_NARROW_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> data_oe[15:8] == 8'h00); // R5

  AST_READ_DRIVES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cs_n && !as_n) && !cs_n && as_n && !wr_hi)
      |=> (oe_n || data_oe[7:0] == 8'hFF)); // R2

  AST_NO_ACCESS_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !as_n) |=> data_oe == 16'h0000); // R1

  AST_DOUBLE_HIGH_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cs_n && as_n) && !cs_n && as_n) |=> data_oe == 16'h0000); // R8

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> data_oe == 16'h0000); // R9

  AST_IRQ_FALL_BY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dl_irq_pd) || $fell(st_irq_pd)) |-> $past(!cs_n)); // R7
endmodule

bind pbus_reg_slave pbus_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .narrow(narrow), .cs_n(cs_n), .as_n(as_n),
  .wr_hi(wr_hi), .oe_n(oe_n), .data_oe(data_oe),
  .dl_irq_pd(dl_irq_pd), .st_irq_pd(st_irq_pd)
);

// File: tb/pbus_reg_slave_tb.sv
module pbus_reg_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow = 1'b0, cs_n = 1'b1, as_n = 1'b1, wr_hi = 1'b0, oe_n = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o, data_oe;
  logic [3:0]  dl_evt = '0;
  logic [5:0]  st_evt = '0;
  logic        dl_irq_pd, st_irq_pd;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pbus_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .cs_n(cs_n), .as_n(as_n),
    .wr_hi(wr_hi), .oe_n(oe_n), .addr_i(addr_i), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe), .dl_evt(dl_evt), .st_evt(st_evt),
    .dl_irq_pd(dl_irq_pd), .st_irq_pd(st_irq_pd)
  );

  // narrow, write, addr, write data, expected read
  localparam logic [37:0] VEC [12] = '{
    {1'b0, 1'b1, 4'h0, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 4'h0, 16'h0000, 16'h1234},
    {1'b1, 1'b1, 4'h3, 16'hFFAB, 16'h0000},
    {1'b1, 1'b1, 4'h2, 16'h77CD, 16'h0000},
    {1'b0, 1'b0, 4'h3, 16'h0000, 16'hABCD},
    {1'b1, 1'b0, 4'h3, 16'h0000, 16'h00AB},
    {1'b1, 1'b0, 4'h1, 16'h0000, 16'h0012},
    {1'b0, 1'b0, 4'hE, 16'h0000, 16'h5A3C},
    {1'b0, 1'b1, 4'hE, 16'hFFFF, 16'h0000},
    {1'b0, 1'b0, 4'hF, 16'h0000, 16'h5A3C},
    {1'b0, 1'b1, 4'h6, 16'h00FF, 16'h0000},
    {1'b0, 1'b0, 4'h6, 16'h0000, 16'h000F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic n, input logic w, input logic [3:0] a,
                        input logic [15:0] wd, output logic [15:0] rd, output logic [15:0] roe);
    @(negedge clk); narrow = n; cs_n = 1'b0; as_n = 1'b0; addr_i = a;
    @(negedge clk); as_n = 1'b1; wr_hi = w;
    @(negedge clk); rd = data_o; roe = data_oe; data_i = wd; as_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; as_n = 1'b1; wr_hi = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] wd);
    logic [15:0] r, e;
    access(1'b0, 1'b1, a, wd, r, e);
  endtask

  task automatic rd16(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] r, e;
    access(1'b0, 1'b0, a, 16'h0, r, e);
    check(req, {e, r}, {16'hFFFF, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r, e;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    @(negedge clk);
    check("R9 reset outputs", {data_oe, 14'h0, dl_irq_pd, st_irq_pd}, 32'h0);
    rd16("R9 reset scratch", 4'h0, 16'h0000);
    rd16("R6 reset status", 4'hC, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      logic [37:0] v;
      v = VEC[i];
      access(v[37], v[36], v[35:32], v[31:16], r, e);
      if (!v[36]) begin
        if (v[37])                check("R5 byte read", {e, r}, {16'h00FF, v[15:0]});
        else if (v[35:33] == 3'd7) check("R6 ident", {e, r}, {16'hFFFF, v[15:0]});
        else if (v[35:33] == 3'd3) check("R10 mask width", {e, r}, {16'hFFFF, v[15:0]});
        else                      check("R4 word read", {e, r}, {16'hFFFF, v[15:0]});
      end
    end

    // R6 strap mirror in status
    access(1'b1, 1'b0, 4'hC, 16'h0, r, e);
    check("R6 strap bit", {e, r}, {16'h00FF, 16'h0002});

    // R2 oe_n high floats lanes during a read
    @(negedge clk); narrow = 1'b0; cs_n = 1'b0; as_n = 1'b0; addr_i = 4'h0; oe_n = 1'b1;
    @(negedge clk); as_n = 1'b1; wr_hi = 1'b0;
    @(negedge clk); check("R2 oe_n high", data_oe, 16'h0000);
    oe_n = 1'b0; #0.5;
    check("R2 oe_n low", {data_oe, data_o}, {16'hFFFF, 16'h1234});
    as_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; as_n = 1'b1;

    // R3 write dropped when cs_n rises before data edge
    @(negedge clk); cs_n = 1'b0; as_n = 1'b0; addr_i = 4'h0;
    @(negedge clk); as_n = 1'b1; wr_hi = 1'b1;
    @(negedge clk); data_i = 16'h5555; cs_n = 1'b1; wr_hi = 1'b0;
    @(negedge clk);
    rd16("R3 aborted write", 4'h0, 16'h1234);
    rd16("R9 abort left status clean", 4'hC, 16'h0000);

    // R1 strobe held low across edges: no access, last address wins
    @(negedge clk); cs_n = 1'b0; as_n = 1'b0; addr_i = 4'h0;
    @(negedge clk); addr_i = 4'hE;
    @(negedge clk); check("R1 no access while strobe low", data_oe, 16'h0000);
    as_n = 1'b1; wr_hi = 1'b0;
    @(negedge clk); check("R1 last address used", {data_oe, data_o}, {16'hFFFF, 16'h5A3C});
    // R8 strobe stays high a second edge
    @(negedge clk); check("R8 no second access", data_oe, 16'h0000);
    cs_n = 1'b1;
    @(negedge clk);
    rd16("R8 error flag set", 4'hC, 16'h0001);
    wr16(4'hC, 16'h0001);
    rd16("R6 error flag cleared", 4'hC, 16'h0000);

    // R7 interrupt groups
    wr16(4'h6, 16'h0000);
    @(negedge clk); dl_evt = 4'b0100;
    @(negedge clk); dl_evt = 4'b0000;
    @(negedge clk); check("R7 masked pending", {dl_irq_pd, st_irq_pd}, 2'b00);
    rd16("R7 pending set", 4'h4, 16'h0004);
    wr16(4'h6, 16'h0004);
    check("R7 unmasked raises", {dl_irq_pd, st_irq_pd}, 2'b10);
    wr16(4'h4, 16'h0004);
    check("R7 write one clears", {dl_irq_pd, st_irq_pd}, 2'b00);
    rd16("R7 pending cleared", 4'h4, 16'h0000);
    wr16(4'hA, 16'hFFFF);
    rd16("R10 status mask width", 4'hA, 16'h003F);
    @(negedge clk); st_evt = 6'b100000;
    @(negedge clk); st_evt = 6'b000000;
    @(negedge clk); check("R7 status group", {dl_irq_pd, st_irq_pd}, 2'b01);

    // R9 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R9 reset irq", {dl_irq_pd, st_irq_pd}, 2'b00);
    rd16("R9 reset scratch again", 4'h0, 16'h0000);
    rd16("R9 reset pending", 4'h8, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule